// File: doc/BRIEF.md
# Sleep Entry and Exit Sequencer

This block paces a storage device into and out of a low-power sleep state. An external, asynchronous, active-high sleep request is first brought into the clock domain. The sequencer then spends a fixed number of clock cycles in an entry phase before it reports sleep. When the request is withdrawn, it spends a fixed number of cycles in an exit phase and then a recovery window before normal accesses are allowed again. Stored data is kept throughout the sleep state. Any access still pending when entry begins is treated as void.

Three outputs steer the surrounding logic. The first reports that sleep is in force. The second tells the access front end to refuse new accesses, from the start of entry to the end of recovery. The third holds the data pins in high impedance during entry, sleep and exit. Two sticky flags record protocol misuse. One is set when the request is seen while the device is still selected. The other is set when the device is selected during the recovery window. Both flags clear only on reset.

Top module: `slp_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, all five outputs are low.
- R2: A raw request level sampled at rising edge k is acted on at edge k+2, after two synchroniser flops. A request first sampled at edge k raises `acc_block` and `dq_hiz` after edge k+2.
- R3: The entry phase lasts ENTRY_CYC cycles (default 2), with `acc_block` and `dq_hiz` high and `sleep_on` low. After that, `sleep_on` goes high and stays high while the synchronised request remains high.
- R4: When the synchronised request falls during sleep, `sleep_on` drops at the next edge. An exit phase of EXIT_CYC cycles (default 2) follows, with `dq_hiz` and `acc_block` high.
- R5: A recovery window of RECOV_CYC cycles (default 2) follows exit, with `acc_block` high and `dq_hiz` low. After it, all three status outputs return low.
- R6: `sel_err` is set at the edge where the synchronised request is high while `dev_sel` is high and the sequencer is awake or entering. It then stays high until reset.
- R7: `rec_err` is set at an edge where `dev_sel` is high during the recovery window. It then stays high until reset.
- R8: If the synchronised request falls during entry, the sequencer moves to the exit phase and `sleep_on` never rises. This also holds when the fall coincides with the last entry cycle.
- R9: Changes of the request during exit or recovery are ignored until the sequencer is awake again. A request still high at that point starts a new entry at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Asynchronous active-high sleep request |
| dev_sel | input | 1 | High while the device is selected by the access front end |
| sleep_on | output | 1 | Sleep state in force |
| acc_block | output | 1 | New accesses must be refused |
| dq_hiz | output | 1 | Data pins must be held in high impedance |
| sel_err | output | 1 | Sticky: sleep was requested while selected |
| rec_err | output | 1 | Sticky: device was selected during recovery |

## Verification
The collision of interest is a request withdrawal that arrives in the same cycle as the last entry cycle. In that cycle, completing entry and aborting it both apply, and abort must win. The bench provokes it with a raw request pulse exactly two clocks wide. The falling synchronised level then lands on the entry cycle whose counter has reached zero. A behavioural reference model, compared every cycle, expects the exit phase with `sleep_on` never rising. A second overlap, a new request arriving during exit, is judged the same way: the model expects that request to be held off until recovery ends.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [2:0] {
        ST_AWAKE  = 3'd0,
        ST_ENTER  = 3'd1,
        ST_ASLEEP = 3'd2,
        ST_EXIT   = 3'd3,
        ST_RECOV  = 3'd4
    } slp_state_e;

    typedef struct packed {
        slp_state_e state;
        logic       sel_err;
        logic       rec_err;
    } slp_ctl_s;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q[STAGES-1];

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_shift_chk
            // R2
            shift_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> st_q[g] == $past(st_q[g-1]));
        end
    endgenerate

endmodule

// File: rtl/slp_cnt.sv
module slp_cnt #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

    // R3
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));

    // R5
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/slp_seq.sv
module slp_seq
    import slp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_CYC   = 2,
    parameter int EXIT_CYC    = 2,
    parameter int RECOV_CYC   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic dev_sel,
    output logic sleep_on,
    output logic acc_block,
    output logic dq_hiz,
    output logic sel_err,
    output logic rec_err
);

    localparam int MAXC = max3(ENTRY_CYC, EXIT_CYC, RECOV_CYC);
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] ENTRY_LD = CW'(ENTRY_CYC - 1);
    localparam logic [CW-1:0] EXIT_LD  = CW'(EXIT_CYC - 1);
    localparam logic [CW-1:0] RECOV_LD = CW'(RECOV_CYC - 1);

    logic          req_s;
    logic          cnt_load;
    logic [CW-1:0] cnt_val;
    logic          cnt_zero;
    slp_ctl_s      ctl_d, ctl_q;

    slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sleep_req),
        .sync_out (req_s)
    );

    slp_cnt #(.W(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    always_comb begin
        ctl_d    = ctl_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (ctl_q.state)
            ST_AWAKE: begin
                if (req_s) begin
                    ctl_d.state = ST_ENTER;
                    cnt_load    = 1'b1;
                    cnt_val     = ENTRY_LD;
                end
            end
            ST_ENTER: begin
                // a withdrawn request beats a finishing entry
                if (!req_s) begin
                    ctl_d.state = ST_EXIT;
                    cnt_load    = 1'b1;
                    cnt_val     = EXIT_LD;
                end else if (cnt_zero) begin
                    ctl_d.state = ST_ASLEEP;
                end
            end
            ST_ASLEEP: begin
                if (!req_s) begin
                    ctl_d.state = ST_EXIT;
                    cnt_load    = 1'b1;
                    cnt_val     = EXIT_LD;
                end
            end
            ST_EXIT: begin
                if (cnt_zero) begin
                    ctl_d.state = ST_RECOV;
                    cnt_load    = 1'b1;
                    cnt_val     = RECOV_LD;
                end
            end
            ST_RECOV: begin
                if (cnt_zero) begin
                    ctl_d.state = ST_AWAKE;
                end
            end
            default: ctl_d.state = ST_AWAKE;
        endcase

        if (req_s && dev_sel &&
            (ctl_q.state == ST_AWAKE || ctl_q.state == ST_ENTER)) begin
            ctl_d.sel_err = 1'b1;
        end
        if (dev_sel && ctl_q.state == ST_RECOV) begin
            ctl_d.rec_err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_AWAKE, sel_err: 1'b0, rec_err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sleep_on  = (ctl_q.state == ST_ASLEEP);
    assign dq_hiz    = (ctl_q.state == ST_ENTER) || (ctl_q.state == ST_ASLEEP) ||
                       (ctl_q.state == ST_EXIT);
    assign acc_block = (ctl_q.state != ST_AWAKE);
    assign sel_err   = ctl_q.sel_err;
    assign rec_err   = ctl_q.rec_err;

    // R3
    asleep_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_on |-> dq_hiz && acc_block);

    // R5
    hiz_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_hiz |-> acc_block);

    // R4
    exit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_on && !req_s) |=> !sleep_on && dq_hiz);

    // R8
    rise_from_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_on) |-> $past(ctl_q.state == ST_ENTER) && $past(req_s));

    // R6
    sel_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |=> sel_err);

    // R7
    rec_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_err |=> rec_err);

endmodule

// File: tb/tb_slp_seq.sv
module tb_slp_seq;

    localparam int CLK_PERIOD = 10;
    localparam int ENTRY_N    = 2;
    localparam int EXIT_N     = 2;
    localparam int RECOV_N    = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic sleep_req;
    logic dev_sel;
    logic sleep_on, acc_block, dq_hiz, sel_err, rec_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    slp_seq dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .dev_sel   (dev_sel),
        .sleep_on  (sleep_on),
        .acc_block (acc_block),
        .dq_hiz    (dq_hiz),
        .sel_err   (sel_err),
        .rec_err   (rec_err)
    );

    int    errors = 0;
    int    checks = 0;
    string tag    = "R1";
    bit    done   = 1'b0;

    task automatic chk(input string t, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", t, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reference model: phases 0 awake, 1 entry, 2 sleep, 3 exit, 4 recovery
    int ph, left;
    bit h1, h2, m_sel, m_rec;

    always @(posedge clk or negedge rst_n) begin : model
        bit seen;
        if (!rst_n) begin
            ph = 0; left = 0; h1 = 0; h2 = 0; m_sel = 0; m_rec = 0;
        end else begin
            seen = h2;
            h2   = h1;
            h1   = sleep_req;
            if (seen && dev_sel && (ph == 0 || ph == 1)) m_sel = 1;
            if (dev_sel && ph == 4) m_rec = 1;
            case (ph)
                0: if (seen) begin ph = 1; left = ENTRY_N; end
                1: begin
                    if (!seen) begin ph = 3; left = EXIT_N; end
                    else begin
                        left--;
                        if (left == 0) ph = 2;
                    end
                end
                2: if (!seen) begin ph = 3; left = EXIT_N; end
                3: begin
                    left--;
                    if (left == 0) begin ph = 4; left = RECOV_N; end
                end
                default: begin
                    left--;
                    if (left == 0) ph = 0;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tag, "sleep_on",  sleep_on,  ph == 2);
            chk(tag, "acc_block", acc_block, ph != 0);
            chk(tag, "dq_hiz",    dq_hiz,    ph == 1 || ph == 2 || ph == 3);
            chk(tag, "sel_err",   sel_err,   m_sel);
            chk(tag, "rec_err",   rec_err,   m_rec);
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sleep_req = 1'b0; dev_sel = 1'b0;
        idle(2);
        chk("R1", "sleep_on in reset",  sleep_on,  1'b0);
        chk("R1", "acc_block in reset", acc_block, 1'b0);
        chk("R1", "dq_hiz in reset",    dq_hiz,    1'b0);
        chk("R1", "sel_err in reset",   sel_err,   1'b0);
        chk("R1", "rec_err in reset",   rec_err,   1'b0);
        rst_n = 1'b1;
        idle(2);

        // plain entry, sleep, exit and recovery
        tag = "R2"; sleep_req = 1'b1; idle(3);
        tag = "R3"; idle(8);
        tag = "R4"; sleep_req = 1'b0; idle(4);
        tag = "R5"; idle(6);

        // request while selected
        tag = "R6"; dev_sel = 1'b1; sleep_req = 1'b1; idle(3);
        dev_sel = 1'b0; idle(6);
        sleep_req = 1'b0; idle(10);

        // selection inside the recovery window
        tag = "R7"; sleep_req = 1'b1; idle(8);
        sleep_req = 1'b0; idle(2);
        dev_sel = 1'b1; idle(4);
        dev_sel = 1'b0; idle(6);

        // withdrawal colliding with the last entry cycle, then a one-cycle pulse
        tag = "R8"; sleep_req = 1'b1; idle(2);
        sleep_req = 1'b0; idle(10);
        sleep_req = 1'b1; idle(1);
        sleep_req = 1'b0; idle(10);

        // new request raised during exit
        tag = "R9"; sleep_req = 1'b1; idle(8);
        sleep_req = 1'b0; idle(3);
        sleep_req = 1'b1; idle(12);
        sleep_req = 1'b0; idle(10);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule